// File: doc/BRIEF.md
# Next Program Counter Unit

This block decides, every clock cycle, the address of the next instruction for a small load/store processor core. It holds the current program counter in a register and, from a decoded control-flow kind, works out the sequential address, a PC-relative conditional branch target, a region-relative absolute jump target or a register-held address. It also says whether control left the straight-line path and, for the call form of the jump, raises a request to write the return address into the link register.

The decoder in front of it supplies the flow kind, the two register values to compare, the 16-bit branch displacement, the 26-bit jump field and the register value used for indirect jumps. The register file behind it takes the link write request. Instruction fetch, hazard logic and delay slots are outside this block.

Top module: `pc_next_unit`

## Requirements
- R1: A high `rst` at a rising clock edge loads `pc_q` with 0 (synchronous reset).
- R2: At every rising edge with `rst` low, `pc_q` takes the value `pc_nxt` showed just before that edge.
- R3: For flow kind 0 (sequential) and the unused codes 6 and 7, `pc_nxt` equals `pc_q`+4, `taken` is 0 and `link_we` is 0.
- R4: For flow kind 1 (branch if equal), when `opnd_a` equals `opnd_b`, `pc_nxt` equals `pc_q`+4 plus the sign-extended `br_off` shifted left by two and `taken` is 1; otherwise `pc_nxt` equals `pc_q`+4 and `taken` is 0.
- R5: For flow kind 2 (branch if different), the target of R4 is used with `taken` 1 when the operands differ; when they are equal `pc_nxt` equals `pc_q`+4 and `taken` is 0.
- R6: For flow kind 3 (jump), `pc_nxt` is bits 31..28 of `pc_q`+4, then `jmp_field` in bits 27..2, then two zero bits; `taken` is 1.
- R7: For flow kind 4 (jump and link), `pc_nxt` and `taken` are as in R6, and `link_we` is 1 with `link_idx` 31 and `link_data` equal to `pc_q`+4.
- R8: For flow kind 5 (jump through register), `pc_nxt` equals `reg_addr` unchanged and `taken` is 1.
- R9: `link_we` is 1 only for flow kind 4.
- R10: All address sums wrap modulo 2^32: a negative displacement below address 0 and an increment past the top of the space give the wrapped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| flow_kind | input | 3 | Decoded control-flow kind (0 seq, 1 beq, 2 bne, 3 jump, 4 jump and link, 5 jump register) |
| opnd_a | input | 32 | First register value for comparison |
| opnd_b | input | 32 | Second register value for comparison |
| br_off | input | 16 | Branch displacement in words, two's complement |
| jmp_field | input | 26 | Word target field of a jump |
| reg_addr | input | 32 | Register value for an indirect jump |
| pc_q | output | 32 | Current program counter |
| pc_nxt | output | 32 | Next program counter |
| taken | output | 1 | Control left the sequential path |
| link_we | output | 1 | Link register write request |
| link_idx | output | 5 | Link register index |
| link_data | output | 32 | Return address to write |

## Verification
The hardest situation to reach is a jump whose upper address bits come from `pc_q`+4 when that sum has just crossed a 256 MB region boundary, together with branches that wrap below zero or past the top of the space; the register only walks there from reset by chance. The stimulus first parks the counter at chosen addresses with register jumps (0x0FFFFFFC, 0xFFFFFFFC, 0) and then issues the jump or branch, before a long random run with a fixed seed in which half the compares are forced equal so both branch outcomes occur often.

// File: rtl/npc_pkg.sv
package npc_pkg;
   typedef enum logic [2:0] {
      FLOW_SEQ = 3'd0,
      FLOW_BEQ = 3'd1,
      FLOW_BNE = 3'd2,
      FLOW_JMP = 3'd3,
      FLOW_JAL = 3'd4,
      FLOW_JR  = 3'd5
   } flow_e;

   localparam int unsigned INSTR_BYTES = 4;
endpackage

// File: rtl/npc_targets.sv
module npc_targets #(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned OFF_W = 16,
   parameter int unsigned TGT_W = 26
) (
   input  logic [PC_W-1:0]  pc,
   input  logic [OFF_W-1:0] off,
   input  logic [TGT_W-1:0] field,
   output logic [PC_W-1:0]  seq_addr,
   output logic [PC_W-1:0]  br_addr,
   output logic [PC_W-1:0]  jmp_addr
);
   localparam int unsigned HI_W = PC_W - TGT_W - 2;

   if (PC_W <= TGT_W + 2) begin : g_bad_width
      $error("npc_targets: PC_W must exceed TGT_W+2");
   end
   if (OFF_W + 2 > PC_W) begin : g_bad_off
      $error("npc_targets: OFF_W too wide for PC_W");
   end

   logic [PC_W-1:0] off_ext;

   always_comb begin
      seq_addr = pc + PC_W'(npc_pkg::INSTR_BYTES);
      off_ext  = {{(PC_W-OFF_W){off[OFF_W-1]}}, off};
      br_addr  = seq_addr + (off_ext << 2);
      jmp_addr = {seq_addr[PC_W-1 -: HI_W], field, 2'b00};
   end
endmodule

// File: rtl/npc_cmp.sv
module npc_cmp #(
   parameter int unsigned DW      = 32,
   parameter bit          XOR_TREE = 1'b1
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic          eq
);
   if (DW < 1) begin : g_bad_dw
      $error("npc_cmp: DW must be at least 1");
   end

   if (XOR_TREE) begin : g_xor
      logic [DW-1:0] diff;
      always_comb begin
         diff = a ^ b;
         eq   = ~|diff;
      end
   end else begin : g_direct
      always_comb eq = (a == b);
   end
endmodule

// File: rtl/npc_select.sv
module npc_select #(
   parameter int unsigned PC_W       = 32,
   parameter bit          JR_CLR_LOW = 1'b0
) (
   input  logic [2:0]      kind,
   input  logic            eq,
   input  logic [PC_W-1:0] seq_addr,
   input  logic [PC_W-1:0] br_addr,
   input  logic [PC_W-1:0] jmp_addr,
   input  logic [PC_W-1:0] reg_addr,
   output logic [PC_W-1:0] pc_nxt,
   output logic            taken,
   output logic            link_we
);
   import npc_pkg::*;

   logic [PC_W-1:0] jr_addr;

   if (JR_CLR_LOW) begin : g_jr_align
      assign jr_addr = {reg_addr[PC_W-1:2], 2'b00};
   end else begin : g_jr_raw
      assign jr_addr = reg_addr;
   end

   always_comb begin
      pc_nxt  = seq_addr;
      taken   = 1'b0;
      link_we = 1'b0;
      case (kind)
         FLOW_BEQ: if (eq) begin
            pc_nxt = br_addr;
            taken  = 1'b1;
         end
         FLOW_BNE: if (!eq) begin
            pc_nxt = br_addr;
            taken  = 1'b1;
         end
         FLOW_JMP: begin
            pc_nxt = jmp_addr;
            taken  = 1'b1;
         end
         FLOW_JAL: begin
            pc_nxt  = jmp_addr;
            taken   = 1'b1;
            link_we = 1'b1;
         end
         FLOW_JR: begin
            pc_nxt = jr_addr;
            taken  = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit #(
   parameter int unsigned PC_W       = 32,
   parameter int unsigned OFF_W      = 16,
   parameter int unsigned TGT_W      = 26,
   parameter int unsigned IDX_W      = 5,
   parameter int unsigned LINK_REG   = 31,
   parameter logic [31:0] RESET_PC   = 32'h0,
   parameter bit          XOR_TREE   = 1'b1,
   parameter bit          JR_CLR_LOW = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [2:0]       flow_kind,
   input  logic [PC_W-1:0]  opnd_a,
   input  logic [PC_W-1:0]  opnd_b,
   input  logic [OFF_W-1:0] br_off,
   input  logic [TGT_W-1:0] jmp_field,
   input  logic [PC_W-1:0]  reg_addr,
   output logic [PC_W-1:0]  pc_q,
   output logic [PC_W-1:0]  pc_nxt,
   output logic             taken,
   output logic             link_we,
   output logic [IDX_W-1:0] link_idx,
   output logic [PC_W-1:0]  link_data
);
   import npc_pkg::*;

   if (LINK_REG >= (1 << IDX_W)) begin : g_bad_link
      $error("pc_next_unit: LINK_REG does not fit in IDX_W bits");
   end
   if (PC_W > 32) begin : g_bad_pc
      $error("pc_next_unit: RESET_PC is limited to 32 bits");
   end

   logic [PC_W-1:0] seq_addr, br_addr, jmp_addr;
   logic            eq;

   npc_targets #(.PC_W(PC_W), .OFF_W(OFF_W), .TGT_W(TGT_W)) u_targets (
      .pc       (pc_q),
      .off      (br_off),
      .field    (jmp_field),
      .seq_addr (seq_addr),
      .br_addr  (br_addr),
      .jmp_addr (jmp_addr)
   );

   npc_cmp #(.DW(PC_W), .XOR_TREE(XOR_TREE)) u_cmp (
      .a  (opnd_a),
      .b  (opnd_b),
      .eq (eq)
   );

   npc_select #(.PC_W(PC_W), .JR_CLR_LOW(JR_CLR_LOW)) u_sel (
      .kind     (flow_kind),
      .eq       (eq),
      .seq_addr (seq_addr),
      .br_addr  (br_addr),
      .jmp_addr (jmp_addr),
      .reg_addr (reg_addr),
      .pc_nxt   (pc_nxt),
      .taken    (taken),
      .link_we  (link_we)
   );

   always_ff @(posedge clk) begin
      if (rst) pc_q <= RESET_PC[PC_W-1:0];
      else     pc_q <= pc_nxt;
   end

   assign link_idx  = IDX_W'(LINK_REG);
   assign link_data = seq_addr;

   // register follows the selected address
   assert_pc_follows_R2: assert property (@(posedge clk) disable iff (rst)
      !rst |=> pc_q == $past(pc_nxt));

   assert_seq_path_R3: assert property (@(posedge clk) disable iff (rst)
      (flow_kind == 3'd0 || flow_kind > 3'd5) |->
         (pc_nxt == pc_q + PC_W'(4) && !taken && !link_we));

   assert_beq_fall_R4: assert property (@(posedge clk) disable iff (rst)
      (flow_kind == 3'd1 && opnd_a != opnd_b) |->
         (pc_nxt == pc_q + PC_W'(4) && !taken));

   assert_bne_fall_R5: assert property (@(posedge clk) disable iff (rst)
      (flow_kind == 3'd2 && opnd_a == opnd_b) |->
         (pc_nxt == pc_q + PC_W'(4) && !taken));

   assert_jump_hi_R6: assert property (@(posedge clk) disable iff (rst)
      (flow_kind == 3'd3) |->
         (taken && pc_nxt[TGT_W+1:2] == jmp_field && pc_nxt[1:0] == 2'b00));

   assert_link_req_R7: assert property (@(posedge clk) disable iff (rst)
      link_we |-> (link_data == pc_q + PC_W'(4) && link_idx == IDX_W'(31)));

   assert_link_only_call_R9: assert property (@(posedge clk) disable iff (rst)
      link_we |-> flow_kind == 3'd4);

   assert_jr_R8: assert property (@(posedge clk) disable iff (rst)
      (flow_kind == 3'd5 && !JR_CLR_LOW) |-> (taken && pc_nxt == reg_addr));
endmodule

// File: tb/test_pc_next_unit.sv
`timescale 1ns/1ps
module test_pc_next_unit;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  flow_kind = 3'd0;
   logic [31:0] opnd_a = 32'd0, opnd_b = 32'd0, reg_addr = 32'd0;
   logic [15:0] br_off = 16'd0;
   logic [25:0] jmp_field = 26'd0;
   logic [31:0] pc_q, pc_nxt, link_data;
   logic        taken, link_we;
   logic [4:0]  link_idx;

   int nchk  = 0;
   int nfail = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   pc_next_unit i_pc_next_unit (
      .clk(clk), .rst(rst), .flow_kind(flow_kind), .opnd_a(opnd_a),
      .opnd_b(opnd_b), .br_off(br_off), .jmp_field(jmp_field),
      .reg_addr(reg_addr), .pc_q(pc_q), .pc_nxt(pc_nxt), .taken(taken),
      .link_we(link_we), .link_idx(link_idx), .link_data(link_data));

   function automatic logic [31:0] exp_next(input logic [2:0] k, input logic [31:0] pc,
         input logic [31:0] a, input logic [31:0] b, input logic [15:0] off,
         input logic [25:0] fld, input logic [31:0] ra);
      logic [31:0] p4, bt, jt;
      p4 = pc + 32'd4;
      bt = p4 + ({{16{off[15]}}, off} << 2);
      jt = {p4[31:28], fld, 2'b00};
      case (k)
         3'd1: return (a == b) ? bt : p4;
         3'd2: return (a != b) ? bt : p4;
         3'd3, 3'd4: return jt;
         3'd5: return ra;
         default: return p4;
      endcase
   endfunction

   function automatic logic exp_taken(input logic [2:0] k, input logic [31:0] a,
         input logic [31:0] b);
      case (k)
         3'd1: return a == b;
         3'd2: return a != b;
         3'd3, 3'd4, 3'd5: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic string tag_of(input logic [2:0] k);
      case (k)
         3'd1: return "R4";
         3'd2: return "R5";
         3'd3: return "R6";
         3'd4: return "R7";
         3'd5: return "R8";
         default: return "R3";
      endcase
   endfunction

   task automatic check(input string tag, input string what, input logic [31:0] act,
         input logic [31:0] expv);
      nchk++;
      if (act !== expv) begin
         nfail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
      end
   endtask

   // one cycle: drive at falling edge, check outputs, then the register
   task automatic step(input logic [2:0] k, input logic [31:0] a, input logic [31:0] b,
         input logic [15:0] off, input logic [25:0] fld, input logic [31:0] ra,
         input string tag);
      logic [31:0] pc0, nx;
      flow_kind = k; opnd_a = a; opnd_b = b; br_off = off; jmp_field = fld; reg_addr = ra;
      #1;
      pc0 = pc_q;
      nx  = exp_next(k, pc0, a, b, off, fld, ra);
      check(tag, "pc_nxt", pc_nxt, nx);
      check(tag, "taken", {31'd0, taken}, {31'd0, exp_taken(k, a, b)});
      check("R9", "link_we", {31'd0, link_we}, {31'd0, k == 3'd4});
      if (k == 3'd4) begin
         check("R7", "link_idx", {27'd0, link_idx}, 32'd31);
         check("R7", "link_data", link_data, pc0 + 32'd4);
      end
      @(negedge clk);
      check("R2", "pc_q", pc_q, nx);
   endtask

   initial begin
      void'($urandom(32'd20241));
      repeat (2) @(negedge clk);
      check("R1", "pc_q after reset", pc_q, 32'h0);
      rst = 1'b0;

      step(3'd0, 0, 0, 0, 0, 0, "R3");
      step(3'd6, 0, 0, 16'h7, 0, 32'h40, "R3");
      step(3'd7, 5, 5, 16'h7, 0, 32'h40, "R3");
      step(3'd1, 32'h11, 32'h11, 16'h0003, 0, 0, "R4");
      step(3'd1, 32'h11, 32'h12, 16'h0003, 0, 0, "R4");
      step(3'd2, 32'h11, 32'h11, 16'hFFFE, 0, 0, "R5");
      step(3'd2, 32'h11, 32'h99, 16'hFFFE, 0, 0, "R5");
      // region boundary: pc+4 crosses into the next 256 MB region
      step(3'd5, 0, 0, 0, 0, 32'h0FFF_FFFC, "R8");
      step(3'd3, 0, 0, 0, 26'h155_5555, 0, "R6");
      step(3'd5, 0, 0, 0, 0, 32'h0FFF_FFFC, "R8");
      step(3'd4, 0, 0, 0, 26'h3FF_FFFF, 0, "R7");
      // wrap at the top and below zero
      step(3'd5, 0, 0, 0, 0, 32'hFFFF_FFFC, "R10");
      step(3'd0, 0, 0, 0, 0, 0, "R10");
      step(3'd1, 7, 7, 16'h8000, 0, 0, "R10");
      step(3'd5, 0, 0, 0, 0, 32'h0000_0000, "R8");
      step(3'd2, 1, 2, 16'hFFFD, 0, 0, "R10");
      step(3'd5, 0, 0, 0, 0, 32'h1234_5677, "R8");

      for (int i = 0; i < 400; i++) begin
         logic [2:0]  k;
         logic [31:0] a, b;
         k = 3'($urandom % 8);
         a = $urandom;
         b = ($urandom % 2 == 0) ? a : $urandom;
         step(k, a, b, 16'($urandom), 26'($urandom), $urandom, tag_of(k));
      end

      // reset in the middle of a run overrides a register jump
      flow_kind = 3'd5; reg_addr = 32'hDEAD_BEE0; rst = 1'b1;
      @(negedge clk);
      check("R1", "pc_q mid-run reset", pc_q, 32'h0);
      rst = 1'b0;
      step(3'd0, 0, 0, 0, 0, 0, "R3");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end
endmodule